// File: doc/BRIEF.md
# System Control Latch and I/O Decoder

This block decodes the 1 MB hardware I/O window of a 24-bit address space (0x300000 to 0x3FFFFF) into the registers and strobes that the rest of a system board uses. A processor-side access comes in as a single request carrying address, size, direction and up to 32 bits of write data. The block turns it into one or two internal 16-bit beats and answers with a single response. Writes update four mode latches, pulse interrupt-acknowledge and watchdog-kick lines, drive three serial clock lines, and strobe a four-register video port. Reads return the input ports, the DIP byte and mirrored video register values.

Each mode latch has two write-only addresses. A write to one sets the latch and a write to the other clears it. The write data plays no part. A long access is carried out as two word beats, upper half first: the beat at the base address carries data[31:16] and the beat at the base address plus two carries data[15:0].

Requests use a valid/ready handshake. `req_ready` is high only when the block is idle, so a request is taken in the cycle where `req_valid` and `req_ready` are both high. The block then holds off further requests until the response has been accepted. The response is also valid/ready. `rsp_valid` stays high, with `rsp_data` unchanged, until the cycle in which `rsp_ready` is high. The consumer may hold `rsp_ready` low for as long as it needs.

Top module: `sysio_ctrl`

## Requirements
- R1: After reset the latches are all 0: cartridge vectors (`vec_bios`=0), palette bank 0, backup RAM writable (`bram_lock`=0) and fix bank 0. All pulses and serial clock lines are low, `req_ready`=1 and `rsp_valid`=0.
- R2: Any write to an address sets or clears its latch, whatever the data. `vec_bios` is set by 0x3A0003 and cleared by 0x3A0013. `pal_bank` is set by 0x3A000F and cleared by 0x3A001F. `bram_lock` is set by 0x3A000D and cleared by 0x3A001D. `fix_bank` is set by 0x3A001B and cleared by 0x3A000B. No other access changes a latch.
- R3: A write to 0x3C000C pulses `irq_ack` for one cycle. `irq_ack[2]` (level 3) comes from data bit 0, `irq_ack[1]` (level 2) from bit 1, and `irq_ack[0]` (level 1) from bit 2.
- R4: Every write to 0x300001 gives exactly one single-cycle pulse on `wdog_kick`.
- R5: A write to 0x380051 sets `rtc_dout` from data bit 0, `rtc_clk` from bit 1 and `rtc_stb` from bit 2. The lines hold those values until the next write to that address.
- R6: A write to 0x3C0000, 0x3C0002, 0x3C0004 or 0x3C0006 raises `vid_wstb` bit 0 (address), bit 1 (data), bit 2 (modulo) or bit 3 (mode) respectively, for one cycle. `vid_wdata` carries the beat's 16-bit data. Writes to other offsets raise no strobe.
- R7: A read at 0x3C0000, 0x3C0002, 0x3C0008 or 0x3C000A returns `vid_vram_in`. A read at 0x3C0004 or 0x3C000C returns `vid_mod_in`. A read at 0x3C0006 or 0x3C000E returns `vid_mode_in`. The size of the access does not narrow these values.
- R8: A read returns a byte port zero-extended in the low byte: `p1_in` at 0x300000, `dip_in` at 0x300001, `stat_a_in` at 0x320001 and `stat_b_in` at 0x380000.
- R9: A read of any other address returns all ones at its size: 0x000000FF for a byte, 0x0000FFFF for a word and 0xFFFFFFFF for a long.
- R10: `req_size` is encoded as 0 for byte, 1 for word and 2 for long (3 behaves as word). A long access runs as a beat at A carrying data[31:16], then a beat at A+2 carrying data[15:0]. A long read returns the A result in [31:16] and the A+2 result in [15:0].
- R11: Each accepted request produces exactly one response. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` are held and `req_ready` stays low. A write's response data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 long |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Write data (low 16 bits for byte/word) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | 32 | Read data (0 for writes) |
| p1_in | input | 8 | Player-1 input port |
| dip_in | input | 8 | DIP switch byte |
| stat_a_in | input | 8 | Status port A |
| stat_b_in | input | 8 | Status port B |
| vid_vram_in | input | 16 | Video VRAM data read value |
| vid_mod_in | input | 16 | Video modulo read value |
| vid_mode_in | input | 16 | Video mode read value |
| vid_wstb | output | 4 | Video register write strobes (addr, data, modulo, mode) |
| vid_wdata | output | 16 | Video register write data |
| irq_ack | output | 3 | Interrupt acknowledge pulses, bit i = level i+1 |
| wdog_kick | output | 1 | Watchdog kick pulse |
| rtc_dout | output | 1 | Serial clock data line |
| rtc_clk | output | 1 | Serial clock clock line |
| rtc_stb | output | 1 | Serial clock strobe line |
| vec_bios | output | 1 | 1 = boot vectors, 0 = cartridge vectors |
| pal_bank | output | 1 | Palette bank select |
| bram_lock | output | 1 | 1 = backup RAM write-protected |
| fix_bank | output | 1 | Fix ROM bank select |

## Verification
The bench checks the bit reversal of the interrupt acknowledge. A design that maps data bits straight across would acknowledge level 1 when level 3 was meant.

It checks the `fix_bank` pair, whose set address is the 0x1x one while the other three latches are set by their 0x0x address. A design that copies the common pattern would invert the fix bank.

Long accesses that straddle two registers must show the upper half on the base address first. Examples are a write to 0x3C0000, which strobes address then data, and a read across modulo and mode. A swapped or repeated beat shows up as misordered strobes or duplicated halves.

It checks size-dependent all-ones returns on undecoded reads. It also holds the response back and expects `rsp_data` to stay fixed with no new request taken. A design that lets a response slip would corrupt it or drop it.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
  localparam int NUM_LATCH = 4;
  localparam int NUM_VREG  = 4;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  localparam logic [7:0] RGN_P1  = 8'h30;
  localparam logic [7:0] RGN_STA = 8'h32;
  localparam logic [7:0] RGN_STB = 8'h38;
  localparam logic [7:0] RGN_SYS = 8'h3A;
  localparam logic [7:0] RGN_VID = 8'h3C;

  localparam logic [15:0] OFF_KICK = 16'h0001;
  localparam logic [15:0] OFF_RTC  = 16'h0051;
  localparam logic [15:0] OFF_IACK = 16'h000C;

  // latch index: 0 vec_bios, 1 pal_bank, 2 bram_lock, 3 fix_bank
  function automatic logic [15:0] latch_set_off(input int idx);
    case (idx)
      0:       return 16'h0003;
      1:       return 16'h000F;
      2:       return 16'h000D;
      default: return 16'h001B;
    endcase
  endfunction

  function automatic logic [15:0] latch_clr_off(input int idx);
    case (idx)
      0:       return 16'h0013;
      1:       return 16'h001F;
      2:       return 16'h001D;
      default: return 16'h000B;
    endcase
  endfunction
endpackage

// File: rtl/sysio_beat_seq.sv
module sysio_beat_seq
  import sysio_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          beat_valid,
  output logic          beat_wr,
  output logic          beat_byte,
  output logic [AW-1:0] beat_addr,
  output logic [DW/2-1:0] beat_data,
  input  logic [DW/2-1:0] beat_rdata
);
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND, S_RESP} st_e;

  st_e           st_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          wr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rsp_q;
  logic          is_long;
  logic [HW-1:0] rd_val;

  assign is_long   = (size_q == SZ_LONG);
  assign req_ready = (st_q == S_IDLE);
  assign rsp_valid = (st_q == S_RESP);
  assign rsp_data  = rsp_q;

  always_comb begin
    beat_valid = (st_q == S_FIRST) || (st_q == S_SECOND);
    beat_wr    = wr_q;
    beat_byte  = (size_q == SZ_BYTE);
    beat_addr  = (st_q == S_SECOND) ? addr_q + AW'(2) : addr_q;
    beat_data  = (is_long && st_q == S_FIRST) ? wdata_q[DW-1:HW] : wdata_q[HW-1:0];
    rd_val     = wr_q ? '0 : beat_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      size_q  <= SZ_WORD;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          size_q  <= req_size;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          st_q    <= S_FIRST;
        end
        S_FIRST: if (is_long) begin
          rsp_q[DW-1:HW] <= rd_val;
          st_q           <= S_SECOND;
        end else begin
          rsp_q <= {{HW{1'b0}}, rd_val};
          st_q  <= S_RESP;
        end
        S_SECOND: begin
          rsp_q[HW-1:0] <= rd_val;
          st_q          <= S_RESP;
        end
        default: if (rsp_ready) st_q <= S_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11
  AST_BEAT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready); // R10
endmodule

// File: rtl/sysio_write_dec.sv
module sysio_write_dec
  import sysio_pkg::*;
#(
  parameter int AW = 24,
  parameter int HW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat_valid,
  input  logic                 beat_wr,
  input  logic [AW-1:0]        beat_addr,
  input  logic [HW-1:0]        beat_data,
  output logic [NUM_LATCH-1:0] latch_q,
  output logic [2:0]           irq_ack,
  output logic                 wdog_kick,
  output logic [2:0]           rtc_q,
  output logic [NUM_VREG-1:0]  vid_wstb,
  output logic [HW-1:0]        vid_wdata
);
  logic [7:0]  region;
  logic [15:0] off;
  logic        wr_hit;

  assign region = beat_addr[AW-1:AW-8];
  assign off    = beat_addr[15:0];
  assign wr_hit = beat_valid && beat_wr;

  for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
    always_ff @(posedge clk) begin
      if (!rst_n) latch_q[g] <= 1'b0;
      else if (wr_hit && region == RGN_SYS) begin
        if (off == latch_set_off(g))      latch_q[g] <= 1'b1;
        else if (off == latch_clr_off(g)) latch_q[g] <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < NUM_VREG; k++) begin : g_vstb
    always_ff @(posedge clk) begin
      if (!rst_n) vid_wstb[k] <= 1'b0;
      else        vid_wstb[k] <= wr_hit && region == RGN_VID && off == 16'(2 * k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_ack   <= '0;
      wdog_kick <= 1'b0;
      rtc_q     <= '0;
      vid_wdata <= '0;
    end else begin
      wdog_kick <= wr_hit && region == RGN_P1 && off == OFF_KICK;
      irq_ack   <= (wr_hit && region == RGN_VID && off == OFF_IACK)
                   ? {beat_data[0], beat_data[1], beat_data[2]} : 3'b000;
      if (wr_hit && region == RGN_STB && off == OFF_RTC) rtc_q <= beat_data[2:0];
      if (wr_hit) vid_wdata <= beat_data;
    end
  end

  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_kick |=> !wdog_kick); // R4
  AST_IACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack != 3'b000) |=> (irq_ack == 3'b000)); // R3
  AST_VSTB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vid_wstb)); // R6
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(latch_q)); // R2
  AST_RTC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(rtc_q)); // R5
endmodule

// File: rtl/sysio_read_mux.sv
module sysio_read_mux
  import sysio_pkg::*;
#(
  parameter int AW = 24,
  parameter int HW = 16
) (
  input  logic [AW-1:0] beat_addr,
  input  logic          beat_byte,
  input  logic [7:0]    p1_in,
  input  logic [7:0]    dip_in,
  input  logic [7:0]    stat_a_in,
  input  logic [7:0]    stat_b_in,
  input  logic [HW-1:0] vid_vram_in,
  input  logic [HW-1:0] vid_mod_in,
  input  logic [HW-1:0] vid_mode_in,
  output logic [HW-1:0] rdata
);
  logic [7:0]  region;
  logic [15:0] off;

  assign region = beat_addr[AW-1:AW-8];
  assign off    = beat_addr[15:0];

  always_comb begin
    rdata = beat_byte ? HW'(8'hFF) : {HW{1'b1}};
    case (region)
      RGN_P1: begin
        if (off == 16'h0000) rdata = HW'(p1_in);
        else if (off == 16'h0001) rdata = HW'(dip_in);
      end
      RGN_STA: if (off == 16'h0001) rdata = HW'(stat_a_in);
      RGN_STB: if (off == 16'h0000) rdata = HW'(stat_b_in);
      RGN_VID: begin
        case (off)
          16'h0000, 16'h0002, 16'h0008, 16'h000A: rdata = vid_vram_in;
          16'h0004, 16'h000C:                     rdata = vid_mod_in;
          16'h0006, 16'h000E:                     rdata = vid_mode_in;
          default: ;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sysio_ctrl.sv
module sysio_ctrl
  import sysio_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic [7:0]    p1_in,
  input  logic [7:0]    dip_in,
  input  logic [7:0]    stat_a_in,
  input  logic [7:0]    stat_b_in,
  input  logic [DW/2-1:0] vid_vram_in,
  input  logic [DW/2-1:0] vid_mod_in,
  input  logic [DW/2-1:0] vid_mode_in,
  output logic [3:0]    vid_wstb,
  output logic [DW/2-1:0] vid_wdata,
  output logic [2:0]    irq_ack,
  output logic          wdog_kick,
  output logic          rtc_dout,
  output logic          rtc_clk,
  output logic          rtc_stb,
  output logic          vec_bios,
  output logic          pal_bank,
  output logic          bram_lock,
  output logic          fix_bank
);
  localparam int HW = DW / 2;

  logic                 beat_valid, beat_wr, beat_byte;
  logic [AW-1:0]        beat_addr;
  logic [HW-1:0]        beat_data, beat_rdata;
  logic [NUM_LATCH-1:0] latch_q;
  logic [2:0]           rtc_q;

  sysio_beat_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .beat_valid(beat_valid), .beat_wr(beat_wr), .beat_byte(beat_byte),
    .beat_addr(beat_addr), .beat_data(beat_data), .beat_rdata(beat_rdata)
  );

  sysio_write_dec #(.AW(AW), .HW(HW)) u_wdec (
    .clk(clk), .rst_n(rst_n),
    .beat_valid(beat_valid), .beat_wr(beat_wr),
    .beat_addr(beat_addr), .beat_data(beat_data),
    .latch_q(latch_q), .irq_ack(irq_ack), .wdog_kick(wdog_kick),
    .rtc_q(rtc_q), .vid_wstb(vid_wstb), .vid_wdata(vid_wdata)
  );

  sysio_read_mux #(.AW(AW), .HW(HW)) u_rmux (
    .beat_addr(beat_addr), .beat_byte(beat_byte),
    .p1_in(p1_in), .dip_in(dip_in), .stat_a_in(stat_a_in), .stat_b_in(stat_b_in),
    .vid_vram_in(vid_vram_in), .vid_mod_in(vid_mod_in), .vid_mode_in(vid_mode_in),
    .rdata(beat_rdata)
  );

  assign vec_bios  = latch_q[0];
  assign pal_bank  = latch_q[1];
  assign bram_lock = latch_q[2];
  assign fix_bank  = latch_q[3];
  assign rtc_dout  = rtc_q[0];
  assign rtc_clk   = rtc_q[1];
  assign rtc_stb   = rtc_q[2];

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !rsp_valid); // R11
endmodule

// File: tb/sysio_ctrl_test.sv
module sysio_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_size = 2'd1;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [7:0]  p1_in = 8'h11, dip_in = 8'hBF, stat_a_in = 8'h22, stat_b_in = 8'h33;
  logic [15:0] vid_vram_in = 16'h1234, vid_mod_in = 16'h0005, vid_mode_in = 16'hABCD;
  logic [3:0]  vid_wstb;
  logic [15:0] vid_wdata;
  logic [2:0]  irq_ack;
  logic        wdog_kick, rtc_dout, rtc_clk, rtc_stb;
  logic        vec_bios, pal_bank, bram_lock, fix_bank;

  int total = 0, bad = 0;

  sysio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .p1_in(p1_in), .dip_in(dip_in), .stat_a_in(stat_a_in), .stat_b_in(stat_b_in),
    .vid_vram_in(vid_vram_in), .vid_mod_in(vid_mod_in), .vid_mode_in(vid_mode_in),
    .vid_wstb(vid_wstb), .vid_wdata(vid_wdata), .irq_ack(irq_ack), .wdog_kick(wdog_kick),
    .rtc_dout(rtc_dout), .rtc_clk(rtc_clk), .rtc_stb(rtc_stb),
    .vec_bios(vec_bios), .pal_bank(pal_bank), .bram_lock(bram_lock), .fix_bank(fix_bank)
  );

  always #10 clk = ~clk;

  // model state
  logic [3:0]  m_latch = '0;  // vec, pal, lock, fix
  logic [2:0]  m_rtc = '0;
  // expected / observed per access
  int          e_kick, o_kick, e_ack_n, o_ack_n, e_vn, o_vn;
  logic [2:0]  e_ack, o_ack;
  logic [31:0] e_rsp, o_rsp;
  int          e_vseq [8], o_vseq [8];
  logic [15:0] e_vdat [8], o_vdat [8];
  int          bp_hold = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mread(input logic [23:0] a, input bit is_byte);
    logic [15:0] o = a[15:0];
    case (a[23:16])
      8'h30: if (o == 16'h0) return {8'h0, p1_in}; else if (o == 16'h1) return {8'h0, dip_in};
      8'h32: if (o == 16'h1) return {8'h0, stat_a_in};
      8'h38: if (o == 16'h0) return {8'h0, stat_b_in};
      8'h3C: begin
        if (o == 16'h0 || o == 16'h2 || o == 16'h8 || o == 16'hA) return vid_vram_in;
        if (o == 16'h4 || o == 16'hC) return vid_mod_in;
        if (o == 16'h6 || o == 16'hE) return vid_mode_in;
      end
      default: ;
    endcase
    return is_byte ? 16'h00FF : 16'hFFFF;
  endfunction

  task automatic model(input logic [23:0] a, input logic [1:0] sz, input bit wr, input logic [31:0] d);
    int nb = (sz == 2'd2) ? 2 : 1;
    e_kick = 0; e_ack = 0; e_ack_n = 0; e_vn = 0; e_rsp = 0;
    for (int b = 0; b < nb; b++) begin
      logic [23:0] ba = a + 24'(2 * b);
      logic [15:0] bd = (nb == 2 && b == 0) ? d[31:16] : d[15:0];
      if (wr) begin
        if (ba[23:16] == 8'h3A)
          case (ba[15:0])
            16'h03: m_latch[0] = 1; 16'h13: m_latch[0] = 0;
            16'h0F: m_latch[1] = 1; 16'h1F: m_latch[1] = 0;
            16'h0D: m_latch[2] = 1; 16'h1D: m_latch[2] = 0;
            16'h1B: m_latch[3] = 1; 16'h0B: m_latch[3] = 0;
            default: ;
          endcase
        if (ba == 24'h300001) e_kick++;
        if (ba == 24'h380051) m_rtc = bd[2:0];
        if (ba == 24'h3C000C && bd[2:0] != 0) begin
          e_ack |= {bd[0], bd[1], bd[2]}; e_ack_n++;
        end
        if (ba[23:16] == 8'h3C && ba[15:0] < 16'h8 && !ba[0]) begin
          e_vseq[e_vn] = int'(ba[2:1]); e_vdat[e_vn] = bd; e_vn++;
        end
      end else if (nb == 2) begin
        if (b == 0) e_rsp[31:16] = mread(ba, 0); else e_rsp[15:0] = mread(ba, 0);
      end else e_rsp = {16'h0, mread(ba, sz == 2'd0)};
    end
  endtask

  task automatic access(input logic [23:0] a, input logic [1:0] sz, input bit wr, input logic [31:0] d);
    bit seen = 0;
    int hold = bp_hold;
    model(a, sz, wr, d);
    o_kick = 0; o_ack = 0; o_ack_n = 0; o_vn = 0; o_rsp = 0;
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_wdata = d; req_valid = 1;
    rsp_ready = (hold == 0);
    @(posedge clk);
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      req_valid = 0;
      if (wdog_kick) o_kick++;
      if (irq_ack != 0) begin o_ack |= irq_ack; o_ack_n++; end
      for (int k = 0; k < 4; k++)
        if (vid_wstb[k] && o_vn < 8) begin o_vseq[o_vn] = k; o_vdat[o_vn] = vid_wdata; o_vn++; end
      if (rsp_valid) begin
        chk(!req_ready, "R11 req_ready low while responding", 32'(req_ready), 0);
        if (seen) chk(rsp_data == o_rsp, "R11 rsp_data held under back-pressure", rsp_data, o_rsp);
        seen = 1; o_rsp = rsp_data;
        if (rsp_ready) break;
        if (hold > 0) hold--; else rsp_ready = 1;
      end
    end
    chk(seen, "R11 response produced", 32'(seen), 1);
    chk(o_rsp == e_rsp, "R7/R8/R9/R10 response data", o_rsp, e_rsp);
    chk(o_kick == e_kick, "R4 kick pulse count", o_kick, e_kick);
    chk(o_ack == e_ack && o_ack_n == e_ack_n, "R3 irq ack bits", {o_ack_n[7:0], 5'b0, o_ack}, {e_ack_n[7:0], 5'b0, e_ack});
    chk(o_vn == e_vn, "R6 video strobe count", o_vn, e_vn);
    for (int i = 0; i < e_vn && i < o_vn; i++) begin
      chk(o_vseq[i] == e_vseq[i], "R10/R6 video strobe order", o_vseq[i], e_vseq[i]);
      chk(o_vdat[i] == e_vdat[i], "R10/R6 video strobe data", o_vdat[i], e_vdat[i]);
    end
    chk({fix_bank, bram_lock, pal_bank, vec_bios} == m_latch, "R2 latch state",
        {fix_bank, bram_lock, pal_bank, vec_bios}, m_latch);
    chk({rtc_stb, rtc_clk, rtc_dout} == m_rtc, "R5 serial clock lines", {rtc_stb, rtc_clk, rtc_dout}, m_rtc);
    rsp_ready = 1;
    bp_hold = 0;
  endtask

  function automatic logic [23:0] pick_addr(input int sel);
    case (sel)
      0: return 24'h300000;  1: return 24'h300001;  2: return 24'h320000;
      3: return 24'h320001;  4: return 24'h380000;  5: return 24'h380051;
      6: return 24'h3A0003;  7: return 24'h3A0013;  8: return 24'h3A000F;
      9: return 24'h3A001F; 10: return 24'h3A000D; 11: return 24'h3A001D;
      12: return 24'h3A000B; 13: return 24'h3A001B;
      14: return 24'h3C0000 + 24'(2 * ($urandom % 9));
      default: return {4'h3, 20'($urandom)};
    endcase
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({fix_bank, bram_lock, pal_bank, vec_bios} == 4'b0, "R1 reset latches", {fix_bank, bram_lock, pal_bank, vec_bios}, 0);
    chk({vid_wstb, irq_ack, wdog_kick, rtc_stb, rtc_clk, rtc_dout} == 0, "R1 reset outputs",
        {vid_wstb, irq_ack, wdog_kick, rtc_stb, rtc_clk, rtc_dout}, 0);
    chk(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);

    // directed corner cases
    access(24'h3A0003, 2'd0, 1, 32'h0);          // R2 set with zero data
    access(24'h3A001B, 2'd0, 1, 32'h0);          // R2 fix bank set via 0x1B
    access(24'h3A000D, 2'd0, 1, 32'hFFFF);       // R2 lock
    access(24'h3C000C, 2'd1, 1, 32'h0001);       // R3 level 3 only
    access(24'h3C000C, 2'd1, 1, 32'h0004);       // R3 level 1 only
    access(24'h300001, 2'd0, 1, 32'h0);          // R4
    access(24'h380051, 2'd0, 1, 32'h0005);       // R5
    access(24'h3C0000, 2'd2, 1, 32'hBEEF_CAFE);  // R10 addr then data strobe
    access(24'h3C0004, 2'd2, 0, 32'h0);          // R10 modulo/mode long read
    access(24'h3C0008, 2'd2, 0, 32'h0);          // R7 mirrors
    access(24'h3D0000, 2'd2, 0, 32'h0);          // R9 long all ones
    access(24'h320000, 2'd0, 0, 32'h0);          // R9 byte all ones
    access(24'h3C0010, 2'd1, 0, 32'h0);          // R9 word all ones
    access(24'h300001, 2'd0, 0, 32'h0);          // R8 dip
    bp_hold = 3;
    access(24'h3C0006, 2'd1, 0, 32'h0);          // R11 back-pressure

    for (int n = 0; n < 400; n++) begin
      logic [23:0] a = pick_addr($urandom % 17);
      logic [1:0] sz;
      if (a[0]) sz = 2'd0; else sz = 2'($urandom % 3);
      if (($urandom % 8) == 0) begin
        p1_in = 8'($urandom); dip_in = 8'($urandom); stat_a_in = 8'($urandom); stat_b_in = 8'($urandom);
        vid_vram_in = 16'($urandom); vid_mod_in = 16'($urandom); vid_mode_in = 16'($urandom);
      end
      if (($urandom % 10) == 0) bp_hold = 1 + ($urandom % 4);
      access(a, sz, 1'($urandom), $urandom);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule